// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits on the host side of a PCI host bridge and presents two 4 KiB register windows to the processor. The first window holds a 32-bit configuration index word. The second window is the configuration data window. Every access to the data window is turned into one request on a downstream configuration bus. The request's address is built from the index word currently stored and the low offset bits of that access.

The index word is read in one of three ways, chosen by its bit 31 and bit 0. With bit 31 set, the word passes through with the access's two low offset bits merged in. With bit 31 clear and bit 0 set, the word is taken as an already-encoded type-1 address, and its low three bits are replaced by the access's offset. With both bits clear, bits 31:11 act as one-hot device selects. The lowest set select is encoded into a binary slot number and packed with the function and register fields into a type-1 style address. Data is little-endian and right-justified: a byte length of 1, 2 or 4 goes out with each request, and write data is passed through unchanged.

The host holds a request until a one-cycle completion pulse. The downstream port uses a valid/ready handshake. For a read, a separate return-valid strobe carries the data, and the host completion waits for that strobe.

Top module: `cfg_addr_xlate`

## Requirements
- R1: After reset, the index word is zero, no downstream request is valid, and no host completion is signalled.
- R2: A write to the index window (`hst_win`=0) stores all 32 bits of `hst_wdata`. A read of the index window returns the stored word. Neither access issues a downstream request.
- R3: If index bit 31 is 1, the downstream address equals the index OR'd with `hst_off[1:0]` in bits 1:0.
- R4: If index bit 31 is 0 and bit 0 is 1, the downstream address is index bits 31:3 followed by `hst_off[2:0]` in bits 2:0.
- R5: If index bits 31 and 0 are both 0, the slot number is the position (11 to 30) of the lowest 1 within index bits 31:11. The address then carries the slot number zero-extended in bits 31:11, index bits 10:8 as the function in bits 10:8, index bits 7:3 in bits 7:3, and `hst_off[2:0]` in bits 2:0.
- R6: In the one-hot format, if index bits 31:11 are all 0, address bits 31:11 are all 1. The lower bits are formed as in R5.
- R7: A data-window access (`hst_win`=1) raises `dn_vld` with `dn_we`=`hst_we`, `dn_len`=`hst_len` and `dn_wdata`=`hst_wdata`. All of these are held unchanged until `dn_rdy`. A write completes to the host after the handshake.
- R8: A data-window read completes to the host only after `dn_rvld`, and `hst_rdata` then equals the `dn_rdata` returned with it.
- R9: The address is computed again for every data access from the index word as it stands at that access. Rewriting the index changes the address of the next access at the same offset.
- R10: `hst_done` is high for exactly one cycle per host access, and never in a cycle where `dn_vld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hst_vld | input | 1 | Host access request, held until `hst_done` |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_win | input | 1 | 0 = index window, 1 = data window |
| hst_off | input | 12 | Byte offset within the 4 KiB window |
| hst_len | input | 3 | Byte length 1, 2 or 4 (data window) |
| hst_wdata | input | 32 | Write data, right-justified |
| hst_done | output | 1 | One-cycle completion pulse |
| hst_rdata | output | 32 | Read data, valid with `hst_done` |
| dn_vld | output | 1 | Downstream request valid |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | 32 | Translated configuration address |
| dn_len | output | 3 | Downstream byte length |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdy | input | 1 | Downstream accepts the request |
| dn_rvld | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The assertions assume that the host keeps `hst_vld` and its fields steady until `hst_done` and drops the request right after. They also assume that the downstream port raises `dn_rvld` only for a read it has accepted, and only in a later cycle than the handshake. The bench's host task drives each access at a falling edge and releases it at the falling edge where it sees the completion. Its downstream model grants `dn_rdy` at random and answers each accepted read once, one to three cycles later. The random index words are drawn across all three formats, including several one-hot selects at once and the empty select field. Offsets are aligned to the byte length chosen.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } xfer_st_e;
endpackage

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] idx_q
);
  logic [DW-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (wr_en) idx_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/cfgx_addr_conv.sv
module cfgx_addr_conv #(
  parameter int DW       = 32,
  parameter int OFF_W    = 12,
  parameter int SLOT_LSB = 11
) (
  input  logic [DW-1:0]    idx,
  input  logic [OFF_W-1:0] off,
  output logic [DW-1:0]    addr
);
  localparam int NSEL  = DW - SLOT_LSB;
  localparam int SW    = $clog2(DW);
  localparam int FN_LSB = 8;
  localparam int PTR_LSB = 3;

  // Priority chain: a select wins only when every lower select is clear.
  logic [NSEL:0]   none_below;
  logic [NSEL-1:0] first_hit;
  assign none_below[0] = 1'b1;

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_sel
      assign first_hit[g]    = idx[SLOT_LSB+g] & none_below[g];
      assign none_below[g+1] = none_below[g] & ~idx[SLOT_LSB+g];
    end
  endgenerate

  logic [SW-1:0]   slot_num;
  logic [NSEL-1:0] slot_field;

  always_comb begin
    slot_num = '0;
    for (int i = 0; i < NSEL; i++) begin
      if (first_hit[i]) slot_num = slot_num | SW'(SLOT_LSB + i);
    end
    if (none_below[NSEL]) slot_field = '1;
    else                  slot_field = NSEL'(slot_num);
  end

  logic [DW-1:0] addr_pass, addr_enc, addr_hot;
  logic          unused_off;
  assign unused_off = ^off[OFF_W-1:3];

  assign addr_pass = {idx[DW-1:2], idx[1:0] | off[1:0]};
  assign addr_enc  = {idx[DW-1:3], off[2:0]};
  assign addr_hot  = {slot_field, idx[SLOT_LSB-1:FN_LSB], idx[FN_LSB-1:PTR_LSB], off[2:0]};

  always_comb begin
    if (idx[DW-1])  addr = addr_pass;
    else if (idx[0]) addr = addr_enc;
    else             addr = addr_hot;
  end
endmodule

// File: rtl/cfgx_req_ctrl.sv
module cfgx_req_ctrl
  import cfgx_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_vld,
  input  logic             hst_we,
  input  logic             hst_win,
  input  logic [LEN_W-1:0] hst_len,
  input  logic [DW-1:0]    hst_wdata,
  input  logic [DW-1:0]    xl_addr,
  input  logic [DW-1:0]    idx_q,
  output logic             idx_wr,
  output logic             hst_done,
  output logic [DW-1:0]    hst_rdata,
  output logic             dn_vld,
  output logic             dn_we,
  output logic [DW-1:0]    dn_addr,
  output logic [LEN_W-1:0] dn_len,
  output logic [DW-1:0]    dn_wdata,
  input  logic             dn_rdy,
  input  logic             dn_rvld,
  input  logic [DW-1:0]    dn_rdata
);
  xfer_st_e st_q, st_d;
  logic             req_ld;
  logic             rd_ld;
  logic [DW-1:0]    rd_d;

  always_comb begin
    st_d   = st_q;
    req_ld = 1'b0;
    rd_ld  = 1'b0;
    rd_d   = dn_rdata;
    idx_wr = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (hst_vld) begin
          if (!hst_win) begin
            idx_wr = hst_we;
            rd_ld  = !hst_we;
            rd_d   = idx_q;
            st_d   = ST_DONE;
          end else begin
            req_ld = 1'b1;
            st_d   = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (dn_rdy) st_d = dn_we ? ST_DONE : ST_WAIT;
      end
      ST_WAIT: begin
        if (dn_rvld) begin
          rd_ld = 1'b1;
          st_d  = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_we    <= 1'b0;
      dn_addr  <= '0;
      dn_len   <= '0;
      dn_wdata <= '0;
    end else if (req_ld) begin
      dn_we    <= hst_we;
      dn_addr  <= xl_addr;
      dn_len   <= hst_len;
      dn_wdata <= hst_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hst_rdata <= '0;
    else if (rd_ld) hst_rdata <= rd_d;
  end

  assign dn_vld   = (st_q == ST_ISSUE);
  assign hst_done = (st_q == ST_DONE);
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate #(
  parameter int DW       = 32,
  parameter int OFF_W    = 12,
  parameter int LEN_W    = 3,
  parameter int SLOT_LSB = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hst_vld,
  input  logic             hst_we,
  input  logic             hst_win,
  input  logic [OFF_W-1:0] hst_off,
  input  logic [LEN_W-1:0] hst_len,
  input  logic [DW-1:0]    hst_wdata,
  output logic             hst_done,
  output logic [DW-1:0]    hst_rdata,
  output logic             dn_vld,
  output logic             dn_we,
  output logic [DW-1:0]    dn_addr,
  output logic [LEN_W-1:0] dn_len,
  output logic [DW-1:0]    dn_wdata,
  input  logic             dn_rdy,
  input  logic             dn_rvld,
  input  logic [DW-1:0]    dn_rdata
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic          idx_wr;
  logic [DW-1:0] idx_q;
  logic [DW-1:0] xl_addr;

  cfgx_index_reg #(.DW(DW)) u_idx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (idx_wr),
    .wr_data (hst_wdata),
    .idx_q   (idx_q)
  );

  cfgx_addr_conv #(.DW(DW), .OFF_W(OFF_W), .SLOT_LSB(SLOT_LSB)) u_conv (
    .idx  (idx_q),
    .off  (hst_off),
    .addr (xl_addr)
  );

  cfgx_req_ctrl #(.DW(DW), .LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .hst_vld   (hst_vld),
    .hst_we    (hst_we),
    .hst_win   (hst_win),
    .hst_len   (hst_len),
    .hst_wdata (hst_wdata),
    .xl_addr   (xl_addr),
    .idx_q     (idx_q),
    .idx_wr    (idx_wr),
    .hst_done  (hst_done),
    .hst_rdata (hst_rdata),
    .dn_vld    (dn_vld),
    .dn_we     (dn_we),
    .dn_addr   (dn_addr),
    .dn_len    (dn_len),
    .dn_wdata  (dn_wdata),
    .dn_rdy    (dn_rdy),
    .dn_rvld   (dn_rvld),
    .dn_rdata  (dn_rdata)
  );
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
  parameter int DW    = 32,
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rst_ok,
  input logic [DW-1:0]    idx_q,
  input logic             dn_vld,
  input logic             dn_rdy,
  input logic             dn_we,
  input logic [DW-1:0]    dn_addr,
  input logic [LEN_W-1:0] dn_len,
  input logic             hst_done
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    dn_vld && !dn_rdy |=> dn_vld && $stable(dn_addr) && $stable(dn_we) && $stable(dn_len));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    hst_done |=> !hst_done);

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    dn_vld |-> !hst_done);

  // R3
  pass_fmt_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(dn_vld) && idx_q[DW-1] |-> dn_addr[DW-1:2] == idx_q[DW-1:2]);

  // R4
  enc_fmt_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(dn_vld) && !idx_q[DW-1] && idx_q[0] |-> dn_addr[DW-1:3] == idx_q[DW-1:3]);

  // R6
  empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(dn_vld) && idx_q[DW-1:11] == '0 && !idx_q[0] |-> &dn_addr[DW-1:11]);
endmodule

bind cfg_addr_xlate cfgx_chk #(.DW(DW), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_sync_n),
  .idx_q    (idx_q),
  .dn_vld   (dn_vld),
  .dn_rdy   (dn_rdy),
  .dn_we    (dn_we),
  .dn_addr  (dn_addr),
  .dn_len   (dn_len),
  .hst_done (hst_done)
);

// File: tb/cfg_addr_xlate_bench.sv
`timescale 1ns/1ps
module cfg_addr_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_vld = 1'b0, hst_we = 1'b0, hst_win = 1'b0;
  logic [11:0] hst_off = '0;
  logic [2:0]  hst_len = 3'd4;
  logic [31:0] hst_wdata = '0;
  logic        hst_done;
  logic [31:0] hst_rdata;
  logic        dn_vld, dn_we;
  logic [31:0] dn_addr, dn_wdata;
  logic [2:0]  dn_len;
  logic        dn_rdy = 1'b0, dn_rvld = 1'b0;
  logic [31:0] dn_rdata = '0;

  always #2.5 clk = ~clk;

  cfg_addr_xlate u_cfg_addr_xlate (.*);

  int errs = 0, checks = 0;
  int cyc = 0;

  // downstream model state
  bit          seen = 0;
  logic [31:0] cap_addr, cap_wdata;
  logic [2:0]  cap_len;
  logic        cap_we;
  bit          rd_pend = 0;
  int          rd_cnt = 0;
  logic [31:0] rd_val;

  localparam logic [31:0] RMASK = 32'h5A5A_0F0F;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(input logic [31:0] ix, input logic [11:0] o);
    logic [31:0] s;
    if (ix[31]) return ix | {30'd0, o[1:0]};
    if (ix[0])  return (ix & 32'hFFFF_FFF8) | {29'd0, o[2:0]};
    s = 32'hFFFF_FFFF;
    for (int b = 31; b >= 11; b--) if (ix[b]) s = b;
    return (ix & 32'h0000_07F8) | {29'd0, o[2:0]} | (s << 11);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      dn_rdy = 0; dn_rvld = 0; rd_pend = 0;
    end else begin
      dn_rvld = 0;
      if (rd_pend) begin
        if (rd_cnt == 0) begin dn_rvld = 1; dn_rdata = rd_val; rd_pend = 0; end
        else rd_cnt--;
      end
      dn_rdy = ($urandom % 4) != 0;
      if (dn_vld && dn_rdy) begin
        seen = 1; cap_addr = dn_addr; cap_we = dn_we; cap_len = dn_len; cap_wdata = dn_wdata;
        if (!dn_we) begin rd_pend = 1; rd_cnt = $urandom % 3; rd_val = dn_addr ^ RMASK; end
      end
    end
  end

  task automatic xfer(input bit win, input bit we, input logic [11:0] off, input logic [2:0] len,
                      input logic [31:0] wd, output logic [31:0] rd);
    int n;
    @(negedge clk);
    seen = 0;
    hst_vld = 1; hst_win = win; hst_we = we; hst_off = off; hst_len = len; hst_wdata = wd;
    n = 0;
    do begin @(negedge clk); n++; end while (!hst_done && n < 2000);
    rd = hst_rdata;
    hst_vld = 0;
    if (n >= 2000) chk(0, "R10 host timeout", n, 0);
    @(negedge clk);
    chk(!hst_done, "R10 single pulse", {31'd0, hst_done}, 0);
  endtask

  logic [31:0] cur_idx;

  task automatic set_idx(input logic [31:0] v);
    logic [31:0] r;
    xfer(0, 1, 12'h000, 3'd4, v, r);
    chk(!seen, "R2 no downstream on index write", {31'd0, seen}, 0);
    cur_idx = v;
  endtask

  task automatic data_acc(input bit we, input logic [11:0] off, input logic [2:0] len,
                          input logic [31:0] wd, input string tag);
    logic [31:0] r, ea;
    ea = model_addr(cur_idx, off);
    xfer(1, we, off, len, wd, r);
    chk(seen && cap_addr == ea, tag, cap_addr, ea);
    chk(cap_we == we && cap_len == len, "R7 we/len", {28'd0, cap_we, cap_len}, {28'd0, we, len});
    if (we) chk(cap_wdata == wd, "R7 wdata", cap_wdata, wd);
    else    chk(r == (ea ^ RMASK), "R8 read data", r, ea ^ RMASK);
  endtask

  function automatic logic [31:0] rand_idx();
    logic [31:0] v;
    int k;
    k = $urandom % 5;
    v = $urandom;
    case (k)
      0: v[31] = 1;
      1: begin v[31] = 0; v[0] = 1; end
      2: begin v = (v & 32'h0000_07FE) | (32'h1 << (11 + $urandom % 20)); end
      3: begin v[31] = 0; v[0] = 0; end
      default: v = v & 32'h0000_07FE;
    endcase
    return v;
  endfunction

  initial begin
    logic [31:0] r, a1;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    chk(!dn_vld && !hst_done, "R1 idle outputs", {30'd0, dn_vld, hst_done}, 0);
    xfer(0, 0, 12'h000, 3'd4, 0, r);
    chk(r == 0, "R1 index after reset", r, 0);
    cur_idx = 0;

    // R2 index write/readback
    set_idx(32'hDEAD_BEEF);
    xfer(0, 0, 12'h004, 3'd4, 0, r);
    chk(r == 32'hDEAD_BEEF, "R2 index readback", r, 32'hDEAD_BEEF);
    chk(!seen, "R2 no downstream on index read", {31'd0, seen}, 0);

    // R3 pass-through format
    set_idx(32'h8000_0102);
    data_acc(0, 12'h001, 3'd1, 0, "R3 pass format");
    chk(cap_addr == 32'h8000_0103, "R3 literal", cap_addr, 32'h8000_0103);

    // R4 pre-encoded format
    set_idx(32'h00AB_CDE1);
    data_acc(1, 12'h006, 3'd2, 32'h0000_1234, "R4 encoded format");
    chk(cap_addr == 32'h00AB_CDE6, "R4 literal", cap_addr, 32'h00AB_CDE6);

    // R5 one-hot single select
    set_idx(32'h0000_2344);
    data_acc(0, 12'h002, 3'd1, 0, "R5 one-hot slot 13");
    chk(cap_addr == 32'h0000_6B42, "R5 literal", cap_addr, 32'h0000_6B42);
    // R5 lowest of several selects wins
    set_idx(32'h0010_1000);
    data_acc(1, 12'h004, 3'd4, 32'hCAFE_F00D, "R5 lowest select");
    chk(cap_addr == 32'h0000_6004, "R5 lowest literal", cap_addr, 32'h0000_6004);

    // R6 empty select field
    set_idx(32'h0000_0578);
    data_acc(0, 12'h005, 3'd1, 0, "R6 empty selects");
    chk(cap_addr == 32'hFFFF_FD7D, "R6 literal", cap_addr, 32'hFFFF_FD7D);

    // R9 same offset, new index
    set_idx(32'h0000_4000);
    data_acc(0, 12'h000, 3'd4, 0, "R9 first index");
    a1 = cap_addr;
    set_idx(32'h4000_0000);
    data_acc(0, 12'h000, 3'd4, 0, "R9 second index");
    chk(cap_addr != a1, "R9 address changed", cap_addr, a1);

    // random mix
    for (int t = 0; t < 400; t++) begin
      logic [2:0]  ln;
      logic [11:0] of;
      int lk;
      if (($urandom % 3) == 0) set_idx(rand_idx());
      lk = $urandom % 3;
      ln = (lk == 0) ? 3'd1 : (lk == 1) ? 3'd2 : 3'd4;
      of = 12'($urandom);
      if (ln == 3'd2) of[0] = 0;
      if (ln == 3'd4) of[1:0] = 0;
      data_acc($urandom % 2, of, ln, $urandom, "R5/R3/R4 random addr");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule